// File: doc/BRIEF.md
# Safety Interlock Shutdown Conditioner

This block takes two independent safety interlock loops, a door loop and an external loop, and turns them into per-loop health indications and a transmitter shutdown path. Each loop is synchronised to the clock and then qualified by an asymmetric timer. A fault must persist for the assert window before the timer accepts it, and the timer forgets accumulated time only after the loop has been healthy for a short release window. An accepted fault is then held for at least a minimum hold time.

The two loop results, together with a supply-good monitor, are combined into a single interlock fault. That fault drives an inhibit for the amplifier supply contactor. A separate class-one fault input joins the interlock fault to set a sticky OFF command. The OFF command is released only by an ON request made while every fault source is quiet. All windows are given in milliseconds and scaled by a clock-rate parameter in kHz.

Top module: `ilk_cond`

## Requirements
- R1: During and right after reset, both loop health outputs are 1, `ilk_fault_o` and `pa_inhibit_o` are 0, and `off_cmd_o` is 1 (the block starts in the OFF state).
- R2: A loop input held at 1 (fault) for less than the assert window (ASSERT_MS × CLK_KHZ cycles) is not recognised. A loop input held longer is recognised within the window plus a few cycles.
- R3: If a loop fault drops out for less than the release window (RELEASE_MS × CLK_KHZ cycles), the fault time already accumulated is kept. If the dropout is longer than the release window, the accumulated time is discarded.
- R4: A recognised loop fault keeps that loop's health output at 0 for at least the hold time (STRETCH_MS × CLK_KHZ cycles), even if the input fault was brief.
- R5: A loop fault held past the hold time keeps the health output at 0 until the input clears. The output then returns to 1 within the release window plus a few cycles.
- R6: Each loop health output (`door_ok_o`, `ext_ok_o`) is 1 when healthy and 0 when faulted. A fault on one loop leaves the other loop's output at 1.
- R7: `ilk_fault_o` is 1 when either loop is faulted, or both are. `pa_inhibit_o` follows it, and any interlock fault sets `off_cmd_o`.
- R8: A 1 on `type1_flt_i` sets `off_cmd_o` but raises neither `ilk_fault_o` nor `pa_inhibit_o`.
- R9: `off_cmd_o` stays 1 until `on_cmd_i` is 1 while no fault source is active. An ON request made during a fault has no effect.
- R10: A 0 on `pwr_ok_i` is treated as an interlock fault with no qualification delay. It raises `ilk_fault_o`, `pa_inhibit_o` and `off_cmd_o` within a few cycles and leaves both loop health outputs at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| door_ilk_i | input | 1 | Door loop, 1 = open (fault), asynchronous |
| ext_ilk_i | input | 1 | External loop, 1 = open (fault), asynchronous |
| pwr_ok_i | input | 1 | Auxiliary supply good, 0 = lost, asynchronous |
| type1_flt_i | input | 1 | Class-one fault from the controller, synchronous |
| on_cmd_i | input | 1 | ON request, synchronous |
| door_ok_o | output | 1 | Door loop health, 0 = faulted |
| ext_ok_o | output | 1 | External loop health, 0 = faulted |
| ilk_fault_o | output | 1 | Combined interlock fault |
| off_cmd_o | output | 1 | Latched OFF command |
| pa_inhibit_o | output | 1 | Amplifier supply contactor inhibit |

## Verification
A miscounting qualification timer shows up at a health output. The output falls too early on a short glitch, or fails to fall once a fault has held for the assert window, and either error is visible within about the assert window. A corrupt hold counter shows up as a health output that returns to 1 sooner or later than the hold time after a brief fault. A corrupt release counter makes the loop drop out too slowly after the input clears, or makes the timer forget accumulated time during a short gap. A wrong OFF latch state appears on the very next cycle, either as an OFF command that clears while a fault is present or as one that ignores a valid ON request.

// File: rtl/ilk_pkg.sv
package ilk_pkg;
  typedef enum int {CH_DOOR = 0, CH_EXT = 1} ilk_ch_e;
  localparam int NUM_CH = 2;

  function automatic int ms_to_cycles(input int khz, input int ms);
    return khz * ms;
  endfunction
endpackage

// File: rtl/ilk_sync.sv
module ilk_sync #(
  parameter int   WIDTH   = 1,
  parameter logic RST_VAL = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= {WIDTH{RST_VAL}};
      sync_q <= {WIDTH{RST_VAL}};
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/ilk_chan.sv
module ilk_chan #(
  parameter int ASSERT_CYC  = 150,
  parameter int RELEASE_CYC = 10,
  parameter int STRETCH_CYC = 500
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_flt_i,
  output logic flt_o
);
  localparam int AW = $clog2(ASSERT_CYC + 1);
  localparam int RW = $clog2(RELEASE_CYC + 1);
  localparam int SW = $clog2(STRETCH_CYC + 1);

  logic          flt_s;
  logic [AW-1:0] acc_q;
  logic [RW-1:0] rel_q;
  logic [SW-1:0] hold_q;
  logic          qual, qual_d, flt_q;

  ilk_sync #(.WIDTH(1), .RST_VAL(1'b0)) sync_i (
    .clk (clk),
    .rst (rst),
    .d_i (raw_flt_i),
    .q_o (flt_s)
  );

  // Fault is accepted once the accumulator reaches the assert window.
  assign qual = (acc_q == AW'(ASSERT_CYC));

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      rel_q  <= '0;
      qual_d <= 1'b0;
      hold_q <= '0;
      flt_q  <= 1'b0;
    end else begin
      // Slow charge while faulted, quick discharge after a healthy run.
      if (flt_s) begin
        rel_q <= '0;
        if (!qual) acc_q <= acc_q + AW'(1);
      end else if (acc_q != '0) begin
        if (rel_q == RW'(RELEASE_CYC - 1)) begin
          acc_q <= '0;
          rel_q <= '0;
        end else begin
          rel_q <= rel_q + RW'(1);
        end
      end
      qual_d <= qual;
      // Minimum-width hold started by each newly accepted fault.
      if (qual && !qual_d)   hold_q <= SW'(STRETCH_CYC);
      else if (hold_q != '0) hold_q <= hold_q - SW'(1);
      flt_q <= qual || (hold_q != '0);
    end
  end

  assign flt_o = flt_q;
endmodule

// File: rtl/ilk_cond.sv
module ilk_cond #(
  parameter int CLK_KHZ    = 100000,
  parameter int ASSERT_MS  = 150,
  parameter int RELEASE_MS = 10,
  parameter int STRETCH_MS = 500
) (
  input  logic clk,
  input  logic rst,
  input  logic door_ilk_i,
  input  logic ext_ilk_i,
  input  logic pwr_ok_i,
  input  logic type1_flt_i,
  input  logic on_cmd_i,
  output logic door_ok_o,
  output logic ext_ok_o,
  output logic ilk_fault_o,
  output logic off_cmd_o,
  output logic pa_inhibit_o
);
  import ilk_pkg::*;

  localparam int ASSERT_CYC  = ms_to_cycles(CLK_KHZ, ASSERT_MS);
  localparam int RELEASE_CYC = ms_to_cycles(CLK_KHZ, RELEASE_MS);
  localparam int STRETCH_CYC = ms_to_cycles(CLK_KHZ, STRETCH_MS);

  logic [NUM_CH-1:0] raw_flt, ch_flt;
  logic              pwr_ok_s, ilk_d, off_set;
  logic              ilk_q, off_q, inh_q;

  assign raw_flt[CH_DOOR] = door_ilk_i;
  assign raw_flt[CH_EXT]  = ext_ilk_i;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    ilk_chan #(
      .ASSERT_CYC  (ASSERT_CYC),
      .RELEASE_CYC (RELEASE_CYC),
      .STRETCH_CYC (STRETCH_CYC)
    ) chan_i (
      .clk       (clk),
      .rst       (rst),
      .raw_flt_i (raw_flt[c]),
      .flt_o     (ch_flt[c])
    );
  end

  ilk_sync #(.WIDTH(1), .RST_VAL(1'b1)) pwr_sync_i (
    .clk (clk),
    .rst (rst),
    .d_i (pwr_ok_i),
    .q_o (pwr_ok_s)
  );

  assign ilk_d   = (|ch_flt) || !pwr_ok_s;
  assign off_set = ilk_d || type1_flt_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      ilk_q <= 1'b0;
      inh_q <= 1'b0;
      off_q <= 1'b1;
    end else begin
      ilk_q <= ilk_d;
      inh_q <= ilk_d;
      if (off_set)       off_q <= 1'b1;
      else if (on_cmd_i) off_q <= 1'b0;
    end
  end

  assign door_ok_o    = !ch_flt[CH_DOOR];
  assign ext_ok_o     = !ch_flt[CH_EXT];
  assign ilk_fault_o  = ilk_q;
  assign off_cmd_o    = off_q;
  assign pa_inhibit_o = inh_q;
endmodule

// File: rtl/ilk_cond_chk.sv
module ilk_cond_chk (
  input logic clk,
  input logic rst,
  input logic type1_flt_i,
  input logic on_cmd_i,
  input logic door_ok_o,
  input logic ext_ok_o,
  input logic ilk_fault_o,
  input logic off_cmd_o,
  input logic pa_inhibit_o
);
  p_ilk_sets_off_r7: assert property (@(posedge clk) disable iff (rst)
    ilk_fault_o |-> off_cmd_o);
  p_inhibit_off_r7: assert property (@(posedge clk) disable iff (rst)
    pa_inhibit_o |-> off_cmd_o);
  p_door_to_or_r6: assert property (@(posedge clk) disable iff (rst)
    !door_ok_o |=> ilk_fault_o);
  p_ext_to_or_r6: assert property (@(posedge clk) disable iff (rst)
    !ext_ok_o |=> ilk_fault_o);
  p_type1_off_r8: assert property (@(posedge clk) disable iff (rst)
    type1_flt_i |=> off_cmd_o);
  p_off_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    off_cmd_o && !on_cmd_i |=> off_cmd_o);
  p_door_hold_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(door_ok_o) |=> !door_ok_o);
  p_ext_hold_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(ext_ok_o) |=> !ext_ok_o);
endmodule

bind ilk_cond ilk_cond_chk chk_i (
  .clk          (clk),
  .rst          (rst),
  .type1_flt_i  (type1_flt_i),
  .on_cmd_i     (on_cmd_i),
  .door_ok_o    (door_ok_o),
  .ext_ok_o     (ext_ok_o),
  .ilk_fault_o  (ilk_fault_o),
  .off_cmd_o    (off_cmd_o),
  .pa_inhibit_o (pa_inhibit_o)
);

// File: tb/ilk_cond_tb_top.sv
module ilk_cond_tb_top;
  localparam int KHZ = 1;
  localparam int AS  = 150;
  localparam int RL  = 10;
  localparam int ST  = 500;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic door_ilk = 1'b0, ext_ilk = 1'b0, pwr_ok = 1'b1, type1 = 1'b0, on_cmd = 1'b0;
  logic door_ok, ext_ok, ilk_fault, off_cmd, pa_inhibit;
  int   n_chk = 0, n_bad = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  ilk_cond #(.CLK_KHZ(KHZ), .ASSERT_MS(AS), .RELEASE_MS(RL), .STRETCH_MS(ST)) dut_i (
    .clk          (clk),
    .rst          (rst),
    .door_ilk_i   (door_ilk),
    .ext_ilk_i    (ext_ilk),
    .pwr_ok_i     (pwr_ok),
    .type1_flt_i  (type1),
    .on_cmd_i     (on_cmd),
    .door_ok_o    (door_ok),
    .ext_ok_o     (ext_ok),
    .ilk_fault_o  (ilk_fault),
    .off_cmd_o    (off_cmd),
    .pa_inhibit_o (pa_inhibit)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_on();
    on_cmd = 1'b1;
    wait_cyc(1);
    on_cmd = 1'b0;
    wait_cyc(2);
  endtask

  task automatic t_reset();
    chk("R1", "door_ok", door_ok, 1'b1);
    chk("R1", "ext_ok", ext_ok, 1'b1);
    chk("R1", "ilk_fault", ilk_fault, 1'b0);
    chk("R1", "pa_inhibit", pa_inhibit, 1'b0);
    chk("R1", "off_cmd", off_cmd, 1'b1);
    pulse_on();
    chk("R9", "off cleared by ON when quiet", off_cmd, 1'b0);
  endtask

  task automatic t_door_persist();
    door_ilk = 1'b1;
    wait_cyc(AS - 3);
    chk("R2", "door not yet recognised", door_ok, 1'b1);
    chk("R2", "no combined fault yet", ilk_fault, 1'b0);
    wait_cyc(13);
    chk("R2", "door recognised", door_ok, 1'b0);
    chk("R6", "ext unaffected by door", ext_ok, 1'b1);
    chk("R7", "combined fault", ilk_fault, 1'b1);
    chk("R7", "inhibit", pa_inhibit, 1'b1);
    chk("R7", "off set", off_cmd, 1'b1);
    wait_cyc(540);
    chk("R5", "door held past stretch", door_ok, 1'b0);
    pulse_on();
    chk("R9", "ON ignored during fault", off_cmd, 1'b1);
    wait_cyc(100);
    door_ilk = 1'b0;
    wait_cyc(5);
    chk("R5", "door still down in release window", door_ok, 1'b0);
    wait_cyc(15);
    chk("R5", "door released fast", door_ok, 1'b1);
    chk("R7", "combined cleared", ilk_fault, 1'b0);
    chk("R9", "off still latched", off_cmd, 1'b1);
    pulse_on();
    chk("R9", "off cleared after fault", off_cmd, 1'b0);
  endtask

  task automatic t_ext_gaps();
    ext_ilk = 1'b1;
    wait_cyc(100);
    chk("R2", "short ext fault ignored", ext_ok, 1'b1);
    ext_ilk = 1'b0;
    wait_cyc(5);
    ext_ilk = 1'b1;
    wait_cyc(100);
    chk("R3", "short gap keeps accumulated time", ext_ok, 1'b0);
    chk("R6", "door unaffected by ext", door_ok, 1'b1);
    ext_ilk = 1'b0;
    wait_cyc(600);
    chk("R4", "ext cleared after hold", ext_ok, 1'b1);
    pulse_on();
    ext_ilk = 1'b1;
    wait_cyc(100);
    ext_ilk = 1'b0;
    wait_cyc(40);
    ext_ilk = 1'b1;
    wait_cyc(100);
    chk("R3", "long gap discards time", ext_ok, 1'b1);
    chk("R3", "no combined fault", ilk_fault, 1'b0);
    chk("R3", "off stays clear", off_cmd, 1'b0);
    ext_ilk = 1'b0;
    wait_cyc(30);
  endtask

  task automatic t_stretch();
    door_ilk = 1'b1;
    wait_cyc(160);
    door_ilk = 1'b0;
    chk("R4", "brief fault recognised", door_ok, 1'b0);
    wait_cyc(400);
    chk("R4", "held for minimum time", door_ok, 1'b0);
    chk("R7", "combined held", ilk_fault, 1'b1);
    wait_cyc(160);
    chk("R4", "released after hold", door_ok, 1'b1);
    pulse_on();
  endtask

  task automatic t_both();
    door_ilk = 1'b1;
    ext_ilk  = 1'b1;
    wait_cyc(165);
    chk("R7", "both door", door_ok, 1'b0);
    chk("R7", "both ext", ext_ok, 1'b0);
    chk("R7", "both combined", ilk_fault, 1'b1);
    door_ilk = 1'b0;
    ext_ilk  = 1'b0;
    wait_cyc(600);
    chk("R7", "both cleared", ilk_fault, 1'b0);
    pulse_on();
  endtask

  task automatic t_type1();
    chk("R9", "start clear", off_cmd, 1'b0);
    type1 = 1'b1;
    wait_cyc(1);
    type1 = 1'b0;
    wait_cyc(2);
    chk("R8", "type1 sets off", off_cmd, 1'b1);
    chk("R8", "type1 no interlock", ilk_fault, 1'b0);
    chk("R8", "type1 no inhibit", pa_inhibit, 1'b0);
    pulse_on();
    chk("R8", "off cleared", off_cmd, 1'b0);
  endtask

  task automatic t_supply();
    pwr_ok = 1'b0;
    wait_cyc(5);
    chk("R10", "supply loss fault", ilk_fault, 1'b1);
    chk("R10", "supply loss inhibit", pa_inhibit, 1'b1);
    chk("R10", "supply loss off", off_cmd, 1'b1);
    chk("R10", "door health unaffected", door_ok, 1'b1);
    chk("R10", "ext health unaffected", ext_ok, 1'b1);
    pwr_ok = 1'b1;
    wait_cyc(5);
    chk("R10", "supply back", ilk_fault, 1'b0);
    chk("R9", "off held", off_cmd, 1'b1);
    pulse_on();
    chk("R9", "off cleared", off_cmd, 1'b0);
  endtask

  initial begin
    wait_cyc(5);
    rst = 1'b0;
    wait_cyc(1);
    t_reset();
    t_door_persist();
    t_ext_gaps();
    t_stretch();
    t_both();
    t_type1();
    t_supply();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule